// File: doc/BRIEF.md
# Status Indicator LED Driver

This block turns a PHY's status signals into three indicator pins and a collision pin. The status inputs are link good, 100 Mb/s speed, full duplex, collision, transmit activity and receive activity. A two-bit mode code decides what the link pin and the activity pin show. A two-bit rate code sets the blink frequency. Three inversion bits set the drive sense of the three indicator pins. An internal millisecond prescaler, derived from the system clock frequency parameter, times two things: the blinking, and a retriggerable stretch that keeps short bursts of activity visible.

A fourth, auxiliary indicator function is also provided. It is off unless enabled. It has a 4-bit function select, and a 2-bit route that places it on one of the three indicator pins or on the collision pin, replacing what that pin would otherwise drive. All configuration arrives as static register inputs. Every output is registered.

Top module: `led_status_drv`

## Requirements
- R1: Mode code bit 0 set (codes 01 and 11) selects mode 1. Code 00 selects mode 2. Code 10 selects mode 3.
- R2: In mode 1 the link pin follows link good. The activity pin is on while stretched activity is active.
- R3: In modes 2 and 3 the link pin is on while link good. While stretched activity is active, the link pin is forced off during the odd half-periods of the blink clock, so it blinks.
- R4: The speed pin is on at 100 Mb/s and off at 10 Mb/s in every mode.
- R5: In mode 2 the activity pin follows the collision input. In mode 3 it shows duplex: on for full duplex, off for half duplex.
- R6: Rate code 00 blinks at 20 Hz, 01 at 10 Hz, 10 at 5 Hz and 11 at 2 Hz. Each half-period is 25, 50, 100 or 250 ms, counted in prescaler ticks of one millisecond each, and the blink phase starts at 0 after reset.
- R7: Inversion bit 0 inverts the link pin, bit 1 the speed pin and bit 2 the activity pin, after any auxiliary routing. The collision pin is never inverted.
- R8: Any transmit or receive activity loads the stretch to 50 ms, and new activity retriggers it. The stretch counts down one step per millisecond tick and is active while nonzero.
- R9: With the auxiliary enable low, the auxiliary function and route fields have no effect on any pin.
- R10: Auxiliary function codes are: 0 link, 1 tx or rx raw activity, 2 tx, 3 rx, 4 collision, 5 100 Mb/s, 6 10 Mb/s, 7 full duplex, 8 link with blink on activity (as in R3), 9 stretched activity, 10 link and 100 Mb/s and full duplex. Codes 11 to 15 drive it inactive (0).
- R11: With auxiliary enable high, route 0 places it on the link pin, 1 on the speed pin, 2 on the activity pin and 3 on the collision pin. On route 3 the collision input is suppressed. Otherwise the collision pin follows the collision input.
- R12: All pins are 0 during reset and reflect the inputs one clock after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link good |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup_i | input | 1 | 1 = full duplex |
| coll_i | input | 1 | Collision present |
| tx_act_i | input | 1 | Transmit activity |
| rx_act_i | input | 1 | Receive activity |
| led_mode_i | input | 2 | Pin mode code (R1) |
| blink_rate_i | input | 2 | Blink rate code (R6) |
| led_pol_i | input | 3 | Per-pin inversion bits (R7) |
| xled_en_i | input | 1 | Auxiliary indicator enable |
| xled_func_i | input | 4 | Auxiliary function code (R10) |
| xled_route_i | input | 2 | Auxiliary pin route (R11) |
| led_link_o | output | 1 | Link indicator pin |
| led_speed_o | output | 1 | Speed indicator pin |
| led_act_o | output | 1 | Activity indicator pin |
| coll_o | output | 1 | Collision pin |

## Verification
A direct input change appears on the pins one clock after the rising edge that samples it. A change that passes through the stretch counter or the blink phase takes one clock to update that state, then one more clock to reach the pins. The blink phase and the stretch both move only on millisecond ticks, so their effects arrive whole ticks later. The bench keeps a behavioural model that steps on each rising edge with this same latency. It compares all four pins on every falling edge, so each result is checked in exactly the cycle it is due. Inputs change only on falling edges.

// File: rtl/led_pkg.sv
package led_pkg;

   // auxiliary indicator function codes
   typedef enum logic [3:0] {
      XF_LINK      = 4'd0,
      XF_ACT_RAW   = 4'd1,
      XF_TX        = 4'd2,
      XF_RX        = 4'd3,
      XF_COLL      = 4'd4,
      XF_SPD100    = 4'd5,
      XF_SPD10     = 4'd6,
      XF_FDX       = 4'd7,
      XF_LINK_BLNK = 4'd8,
      XF_ACT_STR   = 4'd9,
      XF_FAST_FDX  = 4'd10
   } xfunc_e;

   localparam int unsigned BLINK_CW = 8;

   // half period in milliseconds for a rate code
   function automatic logic [BLINK_CW-1:0] blink_half_ms(input logic [1:0] rate);
      case (rate)
         2'd0:    return 8'd25;
         2'd1:    return 8'd50;
         2'd2:    return 8'd100;
         default: return 8'd250;
      endcase
   endfunction

endpackage

// File: rtl/led_timebase.sv
module led_timebase
   import led_pkg::*;
#(
   parameter int unsigned MS_DIV = 100_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_i,
   output logic       tick_o,
   output logic       phase_o
);
   localparam int unsigned CW = (MS_DIV > 2) ? $clog2(MS_DIV) : 1;

   if (MS_DIV < 2) begin : g_bad_div
      $error("led_timebase: MS_DIV must be at least 2");
   end

   logic [CW-1:0]       ms_cnt;
   logic [BLINK_CW-1:0] half_cnt;
   logic [BLINK_CW-1:0] half_lim;

   assign tick_o   = (ms_cnt == CW'(MS_DIV - 1));
   assign half_lim = blink_half_ms(rate_i) - 8'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_cnt <= '0;
      end else if (tick_o) begin
         ms_cnt <= '0;
      end else begin
         ms_cnt <= ms_cnt + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         phase_o  <= 1'b0;
      end else if (tick_o) begin
         if (half_cnt >= half_lim) begin
            half_cnt <= '0;
            phase_o  <= ~phase_o;
         end else begin
            half_cnt <= half_cnt + 8'd1;
         end
      end
   end

   assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |=> $stable(phase_o));

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int unsigned STRETCH_MS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic act_i,
   output logic on_o
);
   localparam int unsigned SW = $clog2(STRETCH_MS + 1);

   if (STRETCH_MS < 1) begin : g_bad_len
      $error("led_stretch: STRETCH_MS must be at least 1");
   end

   logic [SW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
      end else if (act_i) begin
         left <= SW'(STRETCH_MS);
      end else if (tick_i && (left != '0)) begin
         left <= left - SW'(1);
      end
   end

   assign on_o = (left != '0);

   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> on_o);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_i && !tick_i) |=> $stable(left));

endmodule

// File: rtl/led_xsel.sv
module led_xsel
   import led_pkg::*;
(
   input  logic [3:0] func_i,
   input  logic       link_i,
   input  logic       spd_i,
   input  logic       fdx_i,
   input  logic       coll_i,
   input  logic       tx_i,
   input  logic       rx_i,
   input  logic       link_blink_i,
   input  logic       act_str_i,
   output logic       x_o
);
   always_comb begin
      case (func_i)
         XF_LINK:      x_o = link_i;
         XF_ACT_RAW:   x_o = tx_i | rx_i;
         XF_TX:        x_o = tx_i;
         XF_RX:        x_o = rx_i;
         XF_COLL:      x_o = coll_i;
         XF_SPD100:    x_o = spd_i;
         XF_SPD10:     x_o = ~spd_i;
         XF_FDX:       x_o = fdx_i;
         XF_LINK_BLNK: x_o = link_blink_i;
         XF_ACT_STR:   x_o = act_str_i;
         XF_FAST_FDX:  x_o = link_i & spd_i & fdx_i;
         default:      x_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv #(
   parameter int unsigned CLK_HZ     = 100_000_000,
   parameter int unsigned STRETCH_MS = 50,
   parameter int unsigned NPIN       = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link_up_i,
   input  logic       speed100_i,
   input  logic       full_dup_i,
   input  logic       coll_i,
   input  logic       tx_act_i,
   input  logic       rx_act_i,
   input  logic [1:0] led_mode_i,
   input  logic [1:0] blink_rate_i,
   input  logic [2:0] led_pol_i,
   input  logic       xled_en_i,
   input  logic [3:0] xled_func_i,
   input  logic [1:0] xled_route_i,
   output logic       led_link_o,
   output logic       led_speed_o,
   output logic       led_act_o,
   output logic       coll_o
);
   localparam int unsigned MS_DIV = CLK_HZ / 1000;
   localparam logic [1:0]  COLL_ROUTE = 2'(NPIN);

   if (NPIN != 3) begin : g_bad_npin
      $error("led_status_drv: NPIN must be 3");
   end
   if ((CLK_HZ % 1000) != 0 || CLK_HZ < 2000) begin : g_bad_clk
      $error("led_status_drv: CLK_HZ must be a multiple of 1000, at least 2000");
   end

   logic tick, phase, act_str;
   logic mode1, mode3;
   logic link_blink, xf;
   logic [NPIN-1:0] native, pin_d;
   logic coll_d;
   logic [NPIN:0] out_q;

   led_timebase #(.MS_DIV(MS_DIV)) tb_i (
      .clk(clk), .rst_n(rst_n), .rate_i(blink_rate_i),
      .tick_o(tick), .phase_o(phase)
   );

   led_stretch #(.STRETCH_MS(STRETCH_MS)) st_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .act_i(tx_act_i | rx_act_i), .on_o(act_str)
   );

   assign mode1      = led_mode_i[0];
   assign mode3      = led_mode_i[1] & ~led_mode_i[0];
   assign link_blink = link_up_i & ~(act_str & phase);

   led_xsel xs_i (
      .func_i(xled_func_i), .link_i(link_up_i), .spd_i(speed100_i),
      .fdx_i(full_dup_i), .coll_i(coll_i), .tx_i(tx_act_i), .rx_i(rx_act_i),
      .link_blink_i(link_blink), .act_str_i(act_str), .x_o(xf)
   );

   // native pin functions: [0] link, [1] speed, [2] activity
   assign native[0] = mode1 ? link_up_i : link_blink;
   assign native[1] = speed100_i;
   assign native[2] = mode1 ? act_str : (mode3 ? full_dup_i : coll_i);

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic take;
      assign take     = xled_en_i && (xled_route_i == 2'(i));
      assign pin_d[i] = (take ? xf : native[i]) ^ led_pol_i[i];
   end

   assign coll_d = (xled_en_i && (xled_route_i == COLL_ROUTE)) ? xf : coll_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= {coll_d, pin_d};
   end

   assign led_link_o  = out_q[0];
   assign led_speed_o = out_q[1];
   assign led_act_o   = out_q[2];
   assign coll_o      = out_q[NPIN];

   assert_coll_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(xled_en_i && xled_route_i == 2'd3) |=> (coll_o == $past(coll_i)));

   assert_coll_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (xled_en_i && xled_route_i == 2'd3) |=> (coll_o == $past(xf)));

   assert_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(xled_en_i && xled_route_i == 2'd1)
      |=> (led_speed_o == ($past(speed100_i) ^ $past(led_pol_i[1]))));

   assert_idle_xoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!xled_en_i && !led_mode_i[0] && !led_mode_i[1])
      |=> (led_act_o == ($past(coll_i) ^ $past(led_pol_i[2]))));

endmodule

// File: tb/led_status_drv_tb_top.sv
module led_status_drv_tb_top;
   localparam int CLK_HZ = 10_000;
   localparam int MSD    = CLK_HZ / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up_i = 0, speed100_i = 0, full_dup_i = 0, coll_i = 0;
   logic tx_act_i = 0, rx_act_i = 0;
   logic [1:0] led_mode_i = 2'b01, blink_rate_i = 2'b10, xled_route_i = 2'b00;
   logic [2:0] led_pol_i = 3'b000;
   logic xled_en_i = 0;
   logic [3:0] xled_func_i = 4'd0;
   logic led_link_o, led_speed_o, led_act_o, coll_o;

   always #5 clk = ~clk;

   led_status_drv #(.CLK_HZ(CLK_HZ), .STRETCH_MS(50), .NPIN(3)) dut_i (.*);

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R12";
   bit done = 0;

   // behavioural reference
   int m_ms = 0, m_half = 0, m_str = 0;
   bit m_ph = 0;
   bit e_link = 0, e_spd = 0, e_act = 0, e_col = 0;

   function automatic int half_of(input logic [1:0] r);
      case (r)
         2'd0: return 25;
         2'd1: return 50;
         2'd2: return 100;
         default: return 250;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ms = 0; m_half = 0; m_str = 0; m_ph = 0;
         e_link = 0; e_spd = 0; e_act = 0; e_col = 0;
      end else begin
         bit tk, astr, lb, xv, m1, m3;
         bit [3:0] pins;
         tk   = (m_ms == MSD - 1);
         astr = (m_str > 0);
         m1   = led_mode_i[0];
         m3   = (led_mode_i == 2'b10);
         lb   = link_up_i && !(astr && m_ph);
         case (xled_func_i)
            0: xv = link_up_i;
            1: xv = tx_act_i || rx_act_i;
            2: xv = tx_act_i;
            3: xv = rx_act_i;
            4: xv = coll_i;
            5: xv = speed100_i;
            6: xv = !speed100_i;
            7: xv = full_dup_i;
            8: xv = lb;
            9: xv = astr;
            10: xv = link_up_i && speed100_i && full_dup_i;
            default: xv = 0;
         endcase
         pins[0] = m1 ? link_up_i : lb;
         pins[1] = speed100_i;
         pins[2] = m1 ? astr : (m3 ? full_dup_i : coll_i);
         pins[3] = coll_i;
         if (xled_en_i) pins[xled_route_i] = xv;
         e_link = pins[0] ^ led_pol_i[0];
         e_spd  = pins[1] ^ led_pol_i[1];
         e_act  = pins[2] ^ led_pol_i[2];
         e_col  = pins[3];
         // state advance
         if (tx_act_i || rx_act_i) m_str = 50;
         else if (tk && m_str > 0) m_str = m_str - 1;
         if (tk) begin
            if (m_half >= half_of(blink_rate_i) - 1) begin
               m_half = 0; m_ph = !m_ph;
            end else m_half = m_half + 1;
         end
         m_ms = tk ? 0 : m_ms + 1;
      end
   end

   task automatic cmp1(input string pin, input logic got, input bit exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         if (n_bad < 20)
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, pin, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cmp1("led_link_o", led_link_o, e_link);
         cmp1("led_speed_o", led_speed_o, e_spd);
         cmp1("led_act_o", led_act_o, e_act);
         cmp1("coll_o", coll_o, e_col);
      end
   end

   task automatic run(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // random status with activity probability act_pct
   task automatic wander(input int n, input int act_pct);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if ($urandom_range(0, 99) < 3) link_up_i  = ~link_up_i;
         if ($urandom_range(0, 99) < 3) speed100_i = ~speed100_i;
         if ($urandom_range(0, 99) < 3) full_dup_i = ~full_dup_i;
         if ($urandom_range(0, 99) < 5) coll_i     = ~coll_i;
         tx_act_i = ($urandom_range(0, 999) < act_pct);
         rx_act_i = ($urandom_range(0, 999) < act_pct);
      end
      tx_act_i = 0; rx_act_i = 0;
   endtask

   initial begin
      cur_req = "R12";
      run(6);
      rst_n = 1'b1;
      run(4);
      cur_req = "R2";
      led_mode_i = 2'b01;
      wander(2000, 2);
      cur_req = "R1";
      led_mode_i = 2'b11;
      wander(1500, 2);
      cur_req = "R3";
      led_mode_i = 2'b00; blink_rate_i = 2'b00; link_up_i = 1;
      tx_act_i = 1; run(1500); tx_act_i = 0; run(700);
      cur_req = "R5";
      wander(1500, 1);
      led_mode_i = 2'b10;
      wander(1500, 1);
      cur_req = "R4";
      wander(800, 5);
      cur_req = "R6";
      link_up_i = 1;
      for (int r = 0; r < 4; r++) begin
         blink_rate_i = 2'(r);
         rx_act_i = 1;
         run(6000);
         rx_act_i = 0;
      end
      blink_rate_i = 2'b10;
      cur_req = "R7";
      for (int p = 0; p < 8; p++) begin
         led_pol_i = 3'(p);
         wander(400, 3);
      end
      led_pol_i = 3'b000;
      cur_req = "R8";
      led_mode_i = 2'b01;
      run(600);
      tx_act_i = 1; @(negedge clk); tx_act_i = 0;
      run(300);
      rx_act_i = 1; @(negedge clk); rx_act_i = 0;
      run(700);
      cur_req = "R9";
      xled_en_i = 0;
      for (int f = 0; f < 16; f++) begin
         xled_func_i = 4'(f); xled_route_i = 2'(f % 4);
         wander(150, 3);
      end
      cur_req = "R10";
      xled_en_i = 1; xled_route_i = 2'd0; led_mode_i = 2'b00;
      for (int f = 0; f < 16; f++) begin
         xled_func_i = 4'(f);
         wander(500, 3);
      end
      cur_req = "R11";
      for (int r = 0; r < 4; r++) begin
         xled_route_i = 2'(r);
         xled_func_i = 4'd8;
         wander(600, 3);
         xled_func_i = 4'd6;
         wander(300, 3);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(190_000 * 10);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog %s got hung expected completion", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule